// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer with Count-Down Branch

This block is the main control state machine of a small multicycle 32-bit processor. The processor has one shared memory and one shared ALU. In every cycle the sequencer drives the datapath with its steering selects and write strobes:

- memory read and write, and the memory address source;
- instruction register load;
- unconditional and conditional PC load, and the PC source;
- both ALU operand selects and the ALU operation;
- the branch target register load;
- register destination select, write-back source select and register file write.

Its inputs are the opcode field of the instruction register and the zero flag of the ALU.

Every instruction starts with a fetch cycle, which also advances the PC by 4. A decode cycle follows. It reads the registers and stores the branch target, PC+4 plus the scaled displacement, in the target register. After decode the sequencer takes one completion cycle for branch-if-equal or for jump. A third completion state handles a count-down loop instruction, decrement-and-branch-if-not-zero. In that one cycle the ALU computes rs minus a constant 1, and the result is written back to rs through the rt field. The rt field of this instruction always carries a copy of rs. In the same cycle the PC takes the stored target when the result is nonzero.

A polarity select inverts the zero condition for that case. The block also outputs the resulting PC load enable. An opcode that is not decoded sends the sequencer straight back to fetch and causes no writes.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: A synchronous active-low reset puts the sequencer in the fetch state. This holds even when reset is applied in the middle of an instruction.
- R2: In fetch, the sequencer drives `mem_rd`=1, `addr_sel`=0, `ir_wr`=1, `alu_a_sel`=0, `alu_b_sel`=3'b001, `alu_op`=2'b00, `pc_src`=2'b00 and `pc_wr`=1. All other strobes and selects are 0, and `pc_load`=1.
- R3: Fetch is always followed by decode on the next cycle.
- R4: In decode, the sequencer drives `alu_a_sel`=0, `alu_b_sel`=3'b011, `alu_op`=2'b00 and `tgt_wr`=1. Everything else is 0, including `pc_load`.
- R5: Opcode 6'h04 in decode selects the branch-equal state. That state drives `alu_a_sel`=1, `alu_b_sel`=3'b000, `alu_op`=2'b01, `pc_wr_cond`=1, `pc_src`=2'b01 and `cond_inv`=0. In it, `pc_load` equals `alu_zero`.
- R6: Opcode 6'h02 in decode selects the jump state. That state drives `pc_wr`=1 with `pc_src`=2'b10 and nothing else, so `pc_load`=1.
- R7: Opcode 6'h3C in decode selects the count-down state. That state drives `alu_a_sel`=1, `alu_b_sel`=3'b100 (constant 1), `alu_op`=2'b01, `pc_wr_cond`=1, `cond_inv`=1, `pc_src`=2'b01, `reg_dst`=0, `mem_to_reg`=0 and `reg_wr`=1. In it, `pc_load` is the inverse of `alu_zero`.
- R8: Each completion state (branch-equal, jump, count-down) is followed by fetch on the next cycle.
- R9: Any other opcode in decode returns the sequencer to fetch on the next cycle, with no register, memory, target or PC write after the decode cycle.
- R10: `mem_wr` is never asserted, because none of the covered states stores to memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opcode | input | 6 | Opcode field of the instruction register |
| alu_zero | input | 1 | ALU result-is-zero flag |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| addr_sel | output | 1 | Memory address source (0 = PC) |
| ir_wr | output | 1 | Instruction register load |
| pc_wr | output | 1 | Unconditional PC load request |
| pc_wr_cond | output | 1 | Conditional PC load request |
| cond_inv | output | 1 | Conditional load polarity (1 = load when ALU result nonzero) |
| pc_src | output | 2 | PC source: 00 ALU, 01 target register, 10 jump address |
| alu_a_sel | output | 1 | ALU operand A: 0 = PC, 1 = register rs |
| alu_b_sel | output | 3 | ALU operand B: 000 reg, 001 four, 011 scaled offset, 100 constant one |
| alu_op | output | 2 | ALU operation: 00 add, 01 subtract |
| tgt_wr | output | 1 | Branch target register load |
| reg_dst | output | 1 | Register destination select (0 = rt field) |
| mem_to_reg | output | 1 | Write-back source (0 = ALU result) |
| reg_wr | output | 1 | Register file write |
| pc_load | output | 1 | Resulting PC load enable |

## Verification
Each instruction kind is driven through its whole fetch, decode and completion sequence. The full control word is compared in every cycle, so a wrong select value or a missing transition shows up at once. Both branch kinds are run with the zero flag at 0 and at 1. This separates the normal condition from the inverted one: swapping or dropping the polarity select fails exactly one of the two runs. Several undecoded opcodes check that decode falls back to fetch without writes. One of them differs from the count-down opcode by a single bit. A reset applied in the middle of a count-down instruction, and back-to-back instructions, show that the sequence restarts cleanly at fetch.

// File: rtl/mcf_pkg.sv
// Package: shared types and constants for the multicycle control sequencer.
// Assumes a 6-bit opcode and the select widths listed below.
package mcf_pkg;
    localparam int OPC_W  = 6;
    localparam int SELB_W = 3;
    localparam int AOP_W  = 2;
    localparam int SRC_W  = 2;

    localparam logic [OPC_W-1:0] OPC_BEQ_DEF  = 6'h04;
    localparam logic [OPC_W-1:0] OPC_JMP_DEF  = 6'h02;
    localparam logic [OPC_W-1:0] OPC_DBNZ_DEF = 6'h3C;

    typedef enum logic [2:0] {
        ST_FETCH  = 3'd0,
        ST_DECODE = 3'd1,
        ST_BEQ    = 3'd2,
        ST_JMP    = 3'd3,
        ST_CNTDN  = 3'd4
    } state_t;

    typedef struct packed {
        logic              mem_rd;
        logic              mem_wr;
        logic              addr_sel;
        logic              ir_wr;
        logic              pc_wr;
        logic              pc_wr_cond;
        logic              cond_inv;
        logic [SRC_W-1:0]  pc_src;
        logic              alu_a_sel;
        logic [SELB_W-1:0] alu_b_sel;
        logic [AOP_W-1:0]  alu_op;
        logic              tgt_wr;
        logic              reg_dst;
        logic              mem_to_reg;
        logic              reg_wr;
    } ctrl_t;
endpackage

// File: rtl/mcf_next_state.sv
// Next-state logic of the control sequencer.
// Assumes opcode is stable during the decode cycle. Unused encodings recover to fetch.
module mcf_next_state #(
    parameter int                        OPC_W    = mcf_pkg::OPC_W,
    parameter logic [OPC_W-1:0]          OPC_BEQ  = mcf_pkg::OPC_BEQ_DEF,
    parameter logic [OPC_W-1:0]          OPC_JMP  = mcf_pkg::OPC_JMP_DEF,
    parameter logic [OPC_W-1:0]          OPC_DBNZ = mcf_pkg::OPC_DBNZ_DEF
) (
    input  mcf_pkg::state_t  cur,
    input  logic [OPC_W-1:0] opcode,
    output mcf_pkg::state_t  nxt
);
    import mcf_pkg::*;

    // Pick the following state from the current state and the decoded opcode.
    always_comb begin
        nxt = ST_FETCH;
        case (cur)
            ST_FETCH:  nxt = ST_DECODE;
            ST_DECODE: begin
                if (opcode == OPC_BEQ)       nxt = ST_BEQ;
                else if (opcode == OPC_JMP)  nxt = ST_JMP;
                else if (opcode == OPC_DBNZ) nxt = ST_CNTDN;
                else                         nxt = ST_FETCH;
            end
            default:   nxt = ST_FETCH;
        endcase
    end
endmodule

// File: rtl/mcf_ctrl_rom.sv
// Maps the current state to the datapath control word.
// Assumes every field not named for a state is held at 0.
module mcf_ctrl_rom (
    input  mcf_pkg::state_t cur,
    output mcf_pkg::ctrl_t  ctl
);
    import mcf_pkg::*;

    // Produce the control word of each state on top of all-zero defaults.
    always_comb begin
        ctl = '0;
        case (cur)
            ST_FETCH: begin
                ctl.mem_rd    = 1'b1;
                ctl.addr_sel  = 1'b0;
                ctl.ir_wr     = 1'b1;
                ctl.alu_a_sel = 1'b0;
                ctl.alu_b_sel = 3'b001;
                ctl.alu_op    = 2'b00;
                ctl.pc_src    = 2'b00;
                ctl.pc_wr     = 1'b1;
            end
            ST_DECODE: begin
                ctl.alu_a_sel = 1'b0;
                ctl.alu_b_sel = 3'b011;
                ctl.alu_op    = 2'b00;
                ctl.tgt_wr    = 1'b1;
            end
            ST_BEQ: begin
                ctl.alu_a_sel  = 1'b1;
                ctl.alu_b_sel  = 3'b000;
                ctl.alu_op     = 2'b01;
                ctl.pc_wr_cond = 1'b1;
                ctl.pc_src     = 2'b01;
                ctl.cond_inv   = 1'b0;
            end
            ST_JMP: begin
                ctl.pc_wr  = 1'b1;
                ctl.pc_src = 2'b10;
            end
            ST_CNTDN: begin
                ctl.alu_a_sel  = 1'b1;
                ctl.alu_b_sel  = 3'b100;
                ctl.alu_op     = 2'b01;
                ctl.pc_wr_cond = 1'b1;
                ctl.cond_inv   = 1'b1;
                ctl.pc_src     = 2'b01;
                ctl.reg_dst    = 1'b0;
                ctl.mem_to_reg = 1'b0;
                ctl.reg_wr     = 1'b1;
            end
            default: ctl = '0;
        endcase
    end
endmodule

// File: rtl/mcf_pc_gate.sv
// Combines the unconditional and conditional PC requests with the ALU zero flag.
// Assumes cond_inv is meaningful only while pc_wr_cond is set.
module mcf_pc_gate (
    input  logic pc_wr,
    input  logic pc_wr_cond,
    input  logic cond_inv,
    input  logic alu_zero,
    output logic pc_load
);
    // Resolve the PC load enable, with the condition polarity set by cond_inv.
    always_comb begin
        pc_load = pc_wr | (pc_wr_cond & (alu_zero ^ cond_inv));
    end
endmodule

// File: rtl/mc_ctrl_fsm.sv
// Top of the multicycle control sequencer: state register plus its submodules.
// Assumes opcode comes from the instruction register loaded in fetch. Reset is synchronous, active low.
module mc_ctrl_fsm #(
    parameter int                        OPC_W    = mcf_pkg::OPC_W,
    parameter logic [OPC_W-1:0]          OPC_BEQ  = mcf_pkg::OPC_BEQ_DEF,
    parameter logic [OPC_W-1:0]          OPC_JMP  = mcf_pkg::OPC_JMP_DEF,
    parameter logic [OPC_W-1:0]          OPC_DBNZ = mcf_pkg::OPC_DBNZ_DEF
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [OPC_W-1:0]           opcode,
    input  logic                       alu_zero,
    output logic                       mem_rd,
    output logic                       mem_wr,
    output logic                       addr_sel,
    output logic                       ir_wr,
    output logic                       pc_wr,
    output logic                       pc_wr_cond,
    output logic                       cond_inv,
    output logic [mcf_pkg::SRC_W-1:0]  pc_src,
    output logic                       alu_a_sel,
    output logic [mcf_pkg::SELB_W-1:0] alu_b_sel,
    output logic [mcf_pkg::AOP_W-1:0]  alu_op,
    output logic                       tgt_wr,
    output logic                       reg_dst,
    output logic                       mem_to_reg,
    output logic                       reg_wr,
    output logic                       pc_load
);
    import mcf_pkg::*;

    state_t cur_q;
    state_t nxt;
    ctrl_t  ctl;

    // Hold the current state; reset forces fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= ST_FETCH;
        else        cur_q <= nxt;
    end

    mcf_next_state #(
        .OPC_W(OPC_W), .OPC_BEQ(OPC_BEQ), .OPC_JMP(OPC_JMP), .OPC_DBNZ(OPC_DBNZ)
    ) u_next (
        .cur(cur_q), .opcode(opcode), .nxt(nxt)
    );

    mcf_ctrl_rom u_rom (.cur(cur_q), .ctl(ctl));

    mcf_pc_gate u_gate (
        .pc_wr(ctl.pc_wr), .pc_wr_cond(ctl.pc_wr_cond), .cond_inv(ctl.cond_inv),
        .alu_zero(alu_zero), .pc_load(pc_load)
    );

    // Fan the control word out to the individual ports.
    always_comb begin
        mem_rd     = ctl.mem_rd;
        mem_wr     = ctl.mem_wr;
        addr_sel   = ctl.addr_sel;
        ir_wr      = ctl.ir_wr;
        pc_wr      = ctl.pc_wr;
        pc_wr_cond = ctl.pc_wr_cond;
        cond_inv   = ctl.cond_inv;
        pc_src     = ctl.pc_src;
        alu_a_sel  = ctl.alu_a_sel;
        alu_b_sel  = ctl.alu_b_sel;
        alu_op     = ctl.alu_op;
        tgt_wr     = ctl.tgt_wr;
        reg_dst    = ctl.reg_dst;
        mem_to_reg = ctl.mem_to_reg;
        reg_wr     = ctl.reg_wr;
    end
endmodule

// File: rtl/mcf_checker.sv
// Port-level properties of the control sequencer, bound to every instance of the top.
// Assumes fetch is the only state with ir_wr set and decode the only one with tgt_wr set.
module mcf_checker #(
    parameter int               OPC_W    = mcf_pkg::OPC_W,
    parameter logic [OPC_W-1:0] OPC_BEQ  = mcf_pkg::OPC_BEQ_DEF,
    parameter logic [OPC_W-1:0] OPC_JMP  = mcf_pkg::OPC_JMP_DEF,
    parameter logic [OPC_W-1:0] OPC_DBNZ = mcf_pkg::OPC_DBNZ_DEF
) (
    input logic             clk,
    input logic             rst_n,
    input logic [OPC_W-1:0] opcode,
    input logic             alu_zero,
    input logic             mem_wr,
    input logic             ir_wr,
    input logic             pc_wr,
    input logic             pc_wr_cond,
    input logic             cond_inv,
    input logic [1:0]       pc_src,
    input logic             tgt_wr,
    input logic             reg_wr,
    input logic             pc_load
);
    assert_fetch_then_decode_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ir_wr |=> tgt_wr);

    assert_beq_cond_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_wr_cond && !reg_wr) |-> (pc_load == alu_zero));

    assert_jmp_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_wr && opcode == OPC_JMP) |=> (pc_wr && pc_src == 2'b10 && pc_load));

    assert_cntdn_cond_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> (pc_wr_cond && cond_inv && pc_load == !alu_zero));

    assert_done_to_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_wr_cond || (pc_wr && !ir_wr)) |=> ir_wr);

    assert_unknown_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_wr && opcode != OPC_BEQ && opcode != OPC_JMP && opcode != OPC_DBNZ)
        |=> (ir_wr && !reg_wr && !pc_wr_cond));

    assert_no_store_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr);

    assert_one_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ir_wr, tgt_wr, pc_wr_cond}));
endmodule

bind mc_ctrl_fsm mcf_checker #(
    .OPC_W(OPC_W), .OPC_BEQ(OPC_BEQ), .OPC_JMP(OPC_JMP), .OPC_DBNZ(OPC_DBNZ)
) u_mcf_checker (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .alu_zero(alu_zero),
    .mem_wr(mem_wr), .ir_wr(ir_wr), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond),
    .cond_inv(cond_inv), .pc_src(pc_src), .tgt_wr(tgt_wr), .reg_wr(reg_wr),
    .pc_load(pc_load)
);

// File: tb/test_mc_ctrl_fsm.sv
// Directed bench for the control sequencer: one task per scenario, checked at the ports.
module test_mc_ctrl_fsm;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] opcode = 6'h00;
    logic       alu_zero = 1'b0;
    logic       mem_rd, mem_wr, addr_sel, ir_wr, pc_wr, pc_wr_cond, cond_inv;
    logic [1:0] pc_src;
    logic       alu_a_sel;
    logic [2:0] alu_b_sel;
    logic [1:0] alu_op;
    logic       tgt_wr, reg_dst, mem_to_reg, reg_wr, pc_load;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    localparam int K_FETCH = 0, K_DEC = 1, K_BEQ = 2, K_JMP = 3, K_CNT = 4;

    mc_ctrl_fsm i_mc_ctrl_fsm (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .alu_zero(alu_zero),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .addr_sel(addr_sel), .ir_wr(ir_wr),
        .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .cond_inv(cond_inv), .pc_src(pc_src),
        .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .alu_op(alu_op), .tgt_wr(tgt_wr),
        .reg_dst(reg_dst), .mem_to_reg(mem_to_reg), .reg_wr(reg_wr), .pc_load(pc_load)
    );

    always #5 clk = ~clk;

    // Watchdog: a hung run counts as one failed check and still prints the summary.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 5000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog R8 actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    // Order: mem_rd mem_wr addr_sel ir_wr pc_wr pc_wr_cond cond_inv pc_src a_sel b_sel alu_op tgt_wr reg_dst mem_to_reg reg_wr
    function automatic logic [18:0] expw(int k);
        case (k)
            K_FETCH: expw = {1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,2'b00,1'b0,3'b001,2'b00,1'b0,1'b0,1'b0,1'b0};
            K_DEC:   expw = {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,1'b0,3'b011,2'b00,1'b1,1'b0,1'b0,1'b0};
            K_BEQ:   expw = {1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,2'b01,1'b1,3'b000,2'b01,1'b0,1'b0,1'b0,1'b0};
            K_JMP:   expw = {1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,2'b10,1'b0,3'b000,2'b00,1'b0,1'b0,1'b0,1'b0};
            default: expw = {1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,2'b01,1'b1,3'b100,2'b01,1'b0,1'b0,1'b0,1'b1};
        endcase
    endfunction

    function automatic logic [18:0] actw();
        actw = {mem_rd, mem_wr, addr_sel, ir_wr, pc_wr, pc_wr_cond, cond_inv, pc_src,
                alu_a_sel, alu_b_sel, alu_op, tgt_wr, reg_dst, mem_to_reg, reg_wr};
    endfunction

    task automatic chk(string req, logic [18:0] act, logic [18:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic chk_word(string req, int k, logic exp_load);
        chk(req, actw(), expw(k));
        chk({req, " pc_load"}, {18'd0, pc_load}, {18'd0, exp_load});
    endtask

    // Advance one clock and sample 2 ns after the edge.
    task automatic step();
        @(posedge clk);
        #2;
    endtask

    // R1, R2: reset state is fetch with its control word.
    task automatic t_reset();
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
        chk_word("R1 reset->fetch", K_FETCH, 1'b1);
        chk_word("R2 fetch word", K_FETCH, 1'b1);
    endtask

    // One instruction from fetch; k = completion kind or -1 for undecoded.
    task automatic t_instr(string req, logic [5:0] op, logic z, int k, logic exp_load);
        opcode   = op;
        alu_zero = z;
        chk_word("R2 fetch", K_FETCH, 1'b1);
        step();
        chk_word("R3 decode after fetch R4", K_DEC, 1'b0);
        step();
        if (k >= 0) begin
            chk_word(req, k, exp_load);
            step();
            chk_word("R8 back to fetch", K_FETCH, 1'b1);
        end else begin
            chk_word({req, " R9 fetch after decode"}, K_FETCH, 1'b1);
        end
        chk("R10 no store", {18'd0, mem_wr}, 19'd0);
    endtask

    // R1: reset asserted while in the count-down state.
    task automatic t_mid_reset();
        opcode = 6'h3C;
        alu_zero = 1'b0;
        step(); step();
        chk_word("R7 before reset", K_CNT, 1'b1);
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        chk_word("R1 mid-instruction reset", K_FETCH, 1'b1);
    endtask

    initial begin
        #1;
        t_reset();
        t_instr("R5 beq taken",        6'h04, 1'b1, K_BEQ, 1'b1);
        t_instr("R5 beq not taken",    6'h04, 1'b0, K_BEQ, 1'b0);
        t_instr("R6 jump",             6'h02, 1'b0, K_JMP, 1'b1);
        t_instr("R7 cntdn nonzero",    6'h3C, 1'b0, K_CNT, 1'b1);
        t_instr("R7 cntdn reach zero", 6'h3C, 1'b1, K_CNT, 1'b0);
        t_instr("R9 undecoded 00",     6'h00, 1'b1, -1,    1'b0);
        t_instr("R9 undecoded 3D",     6'h3D, 1'b0, -1,    1'b0);
        t_instr("R9 undecoded 23",     6'h23, 1'b0, -1,    1'b0);
        t_mid_reset();
        t_instr("R7 cntdn after reset", 6'h3C, 1'b0, K_CNT, 1'b1);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule